// File: doc/BRIEF.md
# Branch History Table Predictor

This block guesses the direction of a conditional branch while its instruction is still being fetched. A direct-mapped table holds one small prediction entry for each index. The index is taken from the low-order bits of the fetch address, just above the two byte-offset bits. The table has no tag, so two branches whose addresses share those bits share one entry. That aliasing costs accuracy but never correctness. The looked-up entry is returned one clock after the fetch request. The pipeline carries it alongside the instruction until the branch resolves.

When the branch resolves, the pipeline sends back the branch address, the actual direction and the entry value it received at fetch time. The block computes the new entry value from these alone and writes it, so one read port and one write port are enough. The parameter `HYST` selects the entry kind. With `HYST` = 0 the entry is a 1-bit last-outcome flag. With `HYST` = 1 it is a 2-bit saturating counter that changes its guess only after two wrong outcomes in a row.

Top module: `bht_predictor`

## Requirements
- R1: The entry index is `fetch_pc[IDX_W+1:2]` (and `upd_pc[IDX_W+1:2]`), where IDX_W = log2(ENTRIES). Addresses that differ only above bit IDX_W+1 read and write the same entry.
- R2: A fetch request in cycle n gives `pred_valid` = 1 in cycle n+1, together with the entry's state and direction. `pred_valid` is 0 in any cycle that follows a cycle without a fetch request.
- R3: Synchronous reset sets every entry to the start state and clears `pred_valid`. The start state is INIT_STATE (default 2'b01) in 2-bit mode. In 1-bit mode it is INIT_STATE[1] (default 0, not taken).
- R4: In 1-bit mode an update stores the resolved outcome, so a wrong guess inverts the entry. `pred_state` is {1'b0, entry} and `pred_taken` equals the entry.
- R5: In 2-bit mode the encoding is 00 strongly not taken, 01 weakly not taken, 10 weakly taken and 11 strongly taken. `pred_taken` is bit 1 of the state. A taken outcome adds one to the carried state and a not-taken outcome subtracts one.
- R6: In 2-bit mode, after a strong state, one wrong outcome leaves the guess unchanged and a second wrong outcome in a row flips it.
- R7: The 2-bit counter saturates: taken at 11 stays 11, and not taken at 00 stays 00.
- R8: When a fetch and an update hit the same index in the same cycle, the prediction returns the value held before that update.
- R9: A loop-closing branch taken nine times and then not taken once, run twice from reset: on the second run 2-bit mode mispredicts once (the exit) and 1-bit mode mispredicts twice.
- R10: An update presented with `upd_valid` = 0 leaves the table unchanged.
- R11: Address bits 1:0 have no effect on which entry is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Lookup request for the fetch address |
| fetch_pc | input | PC_W | Fetch address |
| pred_valid | output | 1 | Prediction present (one cycle after the request) |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_state | output | 2 | Entry value carried with the instruction |
| upd_valid | input | 1 | Resolved-branch update request |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_state | input | 2 | Entry value the branch received at fetch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
Lookup and update can land in the same cycle. When they hit the same index, the ordering between them becomes visible. The bench drives a fetch and an update of one address in a single cycle and expects the pre-update value. A later fetch of the same address must then show the written value. A behavioural table in the bench models both operations in the order "read old, then write", and every cycle's prediction from both modes is compared against that model.

// File: rtl/bht_pkg.sv
package bht_pkg;

    typedef logic [1:0] bst_t;

    localparam bst_t ST_SNT = 2'b00;
    localparam bst_t ST_WNT = 2'b01;
    localparam bst_t ST_WT  = 2'b10;
    localparam bst_t ST_STK = 2'b11;

    typedef struct packed {
        logic vld;
        bst_t st;
    } pred_t;

    typedef struct packed {
        logic vld;
        bst_t st;
        logic tkn;
    } upd_t;

    function automatic bst_t hyst_next(bst_t cur, logic taken);
        bst_t nxt;
        if (taken) nxt = (cur == ST_STK) ? ST_STK : bst_t'(cur + 2'd1);
        else       nxt = (cur == ST_SNT) ? ST_SNT : bst_t'(cur - 2'd1);
        return nxt;
    endfunction

    function automatic logic state_dir(bst_t st, bit hyst);
        return hyst ? st[1] : st[0];
    endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 12
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    // Byte-offset bits [1:0] are skipped; no tag is kept.
    assign idx = pc[IDX_W+1:2];
endmodule

// File: rtl/bht_next.sv
module bht_next
    import bht_pkg::*;
#(
    parameter bit HYST = 1'b1
) (
    input  bst_t cur,
    input  logic taken,
    output bst_t nxt
);
    generate
        if (HYST) begin : g_hyst
            assign nxt = hyst_next(cur, taken);
        end else begin : g_last
            logic unused_cur;
            assign unused_cur = ^cur;
            assign nxt = {1'b0, taken};
        end
    endgenerate
endmodule

// File: rtl/bht_table.sv
module bht_table
    import bht_pkg::*;
#(
    parameter int   ENTRIES    = 4096,
    parameter int   IDX_W      = 12,
    parameter bit   HYST       = 1'b1,
    parameter bst_t INIT_STATE = ST_WNT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output pred_t            rd_out,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  bst_t             wr_state
);
    localparam int ST_W = HYST ? 2 : 1;

    logic [ST_W-1:0] mem [ENTRIES];
    logic [ST_W-1:0] init_w;
    logic [ST_W-1:0] wr_w;
    logic [ST_W-1:0] rd_w;
    bst_t            rd_st;
    pred_t           out_q;

    generate
        if (HYST) begin : g_w2
            assign init_w = INIT_STATE;
            assign wr_w   = wr_state;
            assign rd_st  = rd_w;
        end else begin : g_w1
            logic unused_hi;
            assign unused_hi = wr_state[1];
            assign init_w = INIT_STATE[1];
            assign wr_w   = wr_state[0];
            assign rd_st  = {1'b0, rd_w};
        end
    endgenerate

    assign rd_w = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= init_w;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_w;
        end
    end

    // Read samples the pre-write contents at the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.vld <= rd_en;
            if (rd_en) out_q.st <= rd_st;
        end
    end

    assign rd_out = out_q;
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
    import bht_pkg::*;
#(
    parameter int   PC_W       = 32,
    parameter int   ENTRIES    = 4096,
    parameter bit   HYST       = 1'b1,
    parameter bst_t INIT_STATE = ST_WNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fetch_valid,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_valid,
    output logic            pred_taken,
    output logic [1:0]      pred_state,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [1:0]      upd_state,
    input  logic            upd_taken
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    pred_t            rd_out;
    upd_t             upd;
    bst_t             wr_state;

    assign upd = '{vld: upd_valid, st: upd_state, tkn: upd_taken};

    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_rd_idx (
        .pc  (fetch_pc),
        .idx (rd_idx)
    );

    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_wr_idx (
        .pc  (upd_pc),
        .idx (wr_idx)
    );

    bht_next #(.HYST(HYST)) u_next (
        .cur   (upd.st),
        .taken (upd.tkn),
        .nxt   (wr_state)
    );

    bht_table #(
        .ENTRIES    (ENTRIES),
        .IDX_W      (IDX_W),
        .HYST       (HYST),
        .INIT_STATE (INIT_STATE)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (fetch_valid),
        .rd_idx   (rd_idx),
        .rd_out   (rd_out),
        .wr_en    (upd.vld),
        .wr_idx   (wr_idx),
        .wr_state (wr_state)
    );

    assign pred_valid = rd_out.vld;
    assign pred_state = rd_out.st;
    assign pred_taken = state_dir(rd_out.st, HYST);
endmodule

// File: rtl/bht_predictor_chk.sv
module bht_predictor_chk #(
    parameter bit HYST = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       fetch_valid,
    input logic       pred_valid,
    input logic       upd_valid,
    input logic       upd_taken,
    input logic [1:0] upd_state,
    input logic [1:0] wr_state
);
    // R2
    lookup_lat_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |=> pred_valid);

    // R2
    no_lookup_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |=> !pred_valid);

    // R3
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !pred_valid);

    generate
        if (HYST) begin : g_hyst
            // R5
            up_dir_chk: assert property (@(posedge clk) disable iff (rst)
                (upd_valid && upd_taken) |-> (wr_state >= upd_state));

            // R5
            down_dir_chk: assert property (@(posedge clk) disable iff (rst)
                (upd_valid && !upd_taken) |-> (wr_state <= upd_state));

            // R7
            sat_top_chk: assert property (@(posedge clk) disable iff (rst)
                (upd_valid && upd_taken && upd_state == 2'b11) |-> (wr_state == 2'b11));

            // R7
            sat_bot_chk: assert property (@(posedge clk) disable iff (rst)
                (upd_valid && !upd_taken && upd_state == 2'b00) |-> (wr_state == 2'b00));
        end
    endgenerate
endmodule

bind bht_predictor bht_predictor_chk #(.HYST(HYST)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_valid (fetch_valid),
    .pred_valid  (pred_valid),
    .upd_valid   (upd_valid),
    .upd_taken   (upd_taken),
    .upd_state   (upd_state),
    .wr_state    (wr_state)
);

// File: tb/bht_predictor_tb.sv
`timescale 1ns/1ps
module bht_predictor_tb;
    localparam int N2 = 4096;
    localparam int N1 = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fv  = 1'b0;
    logic [31:0] fpc = '0;
    logic        uv  = 1'b0;
    logic [31:0] upc = '0;
    logic [1:0]  us2 = '0;
    logic [1:0]  us1 = '0;
    logic        ut  = 1'b0;

    logic       pv2, pt2, pv1, pt1;
    logic [1:0] ps2, ps1;

    int total = 0;
    int bad   = 0;
    int m2 [N2];
    int m1 [N1];
    int o_s2, o_s1;
    int miss2, miss1;

    always #10 clk = ~clk;

    bht_predictor u_dut (
        .clk(clk), .rst(rst), .fetch_valid(fv), .fetch_pc(fpc),
        .pred_valid(pv2), .pred_taken(pt2), .pred_state(ps2),
        .upd_valid(uv), .upd_pc(upc), .upd_state(us2), .upd_taken(ut)
    );

    bht_predictor #(.ENTRIES(N1), .HYST(1'b0)) u_dut_lo (
        .clk(clk), .rst(rst), .fetch_valid(fv), .fetch_pc(fpc),
        .pred_valid(pv1), .pred_taken(pt1), .pred_state(ps1),
        .upd_valid(uv), .upd_pc(upc), .upd_state(us1), .upd_taken(ut)
    );

    function automatic int ix(logic [31:0] pc, int n);
        return int'((pc >> 2) % n);
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, model "read old then write", compare at next negedge.
    task automatic step(input logic f, input logic [31:0] fp, input logic u,
                        input logic [31:0] up, input logic t, input string tag);
        int e_s2, e_s1;
        fv = f; fpc = fp; uv = u; upc = up; ut = t;
        us2 = 2'(m2[ix(up, N2)]);
        us1 = 2'(m1[ix(up, N1)]);
        e_s2 = m2[ix(fp, N2)];
        e_s1 = m1[ix(fp, N1)];
        if (u) begin
            if (t) m2[ix(up, N2)] = (us2 == 3) ? 3 : us2 + 1;
            else   m2[ix(up, N2)] = (us2 == 0) ? 0 : us2 - 1;
            m1[ix(up, N1)] = t ? 1 : 0;
        end
        @(posedge clk);
        @(negedge clk);
        fv = 1'b0; uv = 1'b0;
        chk({tag, " R2 valid2"}, int'(pv2), int'(f));
        chk({tag, " R2 valid1"}, int'(pv1), int'(f));
        if (f) begin
            chk({tag, " R5 state2"}, int'(ps2), e_s2);
            chk({tag, " R5 taken2"}, int'(pt2), (e_s2 >= 2) ? 1 : 0);
            chk({tag, " R4 state1"}, int'(ps1), e_s1);
            chk({tag, " R4 taken1"}, int'(pt1), e_s1);
            o_s2 = int'(ps2);
            o_s1 = int'(ps1);
        end
    endtask

    task automatic fetch(logic [31:0] pc, string tag);
        step(1'b1, pc, 1'b0, 32'h0, 1'b0, tag);
    endtask

    task automatic update(logic [31:0] pc, logic t, string tag);
        step(1'b0, 32'h0, 1'b1, pc, t, tag);
    endtask

    // Fetch, then resolve; counts mispredictions per mode.
    task automatic run_branch(logic [31:0] pc, logic t, string tag);
        fetch(pc, tag);
        if ((o_s2 >= 2) != t) miss2++;
        if ((o_s1 == 1) != t) miss1++;
        update(pc, t, tag);
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N2; i++) m2[i] = 1;
        for (int i = 0; i < N1; i++) m1[i] = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R3 reset state
        chk("R3 valid after reset", int'(pv2), 0);
        fetch(32'h100, "R3 start");

        // R1 / R11 index and aliasing
        update(32'h100, 1'b1, "R1 train");
        fetch(32'h103, "R11 low bits");
        fetch(32'h100 + 32'(4 * N2), "R1 alias");
        fetch(32'h104, "R1 neighbour");

        // R10 ignored update
        step(1'b0, 32'h0, 1'b0, 32'h104, 1'b1, "R10 idle");
        fetch(32'h104, "R10 unchanged");
        chk("R10 neighbour2", o_s2, 1);

        // R7 saturation high then R6 hysteresis
        for (int i = 0; i < 4; i++) update(32'h200, 1'b1, "R7 up");
        fetch(32'h200, "R7 top");
        chk("R7 top2", o_s2, 3);
        update(32'h200, 1'b0, "R6 miss1");
        fetch(32'h200, "R6 hold");
        chk("R6 still taken", (o_s2 >= 2) ? 1 : 0, 1);
        update(32'h200, 1'b0, "R6 miss2");
        fetch(32'h200, "R6 flip");
        chk("R6 flipped", (o_s2 >= 2) ? 1 : 0, 0);
        for (int i = 0; i < 3; i++) update(32'h200, 1'b0, "R7 down");
        fetch(32'h200, "R7 bottom");
        chk("R7 bottom2", o_s2, 0);

        // R8 same-cycle read and write
        step(1'b1, 32'h300, 1'b1, 32'h300, 1'b1, "R8 collide");
        chk("R8 old value", o_s2, 1);
        fetch(32'h300, "R8 after");
        chk("R8 new value", o_s2, 2);

        // R4 alternating pattern
        for (int i = 0; i < 4; i++) run_branch(32'h500, 1'(i % 2), "R4 alt");

        // R9 loop of ten, two passes
        for (int i = 0; i < 10; i++) run_branch(32'h400, (i < 9), "R9 pass1");
        miss2 = 0; miss1 = 0;
        for (int i = 0; i < 10; i++) run_branch(32'h400, (i < 9), "R9 pass2");
        chk("R9 misses 2-bit", miss2, 1);
        chk("R9 misses 1-bit", miss1, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule